// File: doc/BRIEF.md
# Rail-Gated Input Freeze Bank

This block sits between a bank of input pins and the internal routing of a low-power device. One shared gating rail decides, cycle by cycle, whether the selected inputs are allowed to reach the logic behind them. A per-pin membership mask picks which inputs take part. While the rail is high, every member input is frozen at the last value it carried before the rail rose. Internal logic then sees a steady level instead of a toggling signal, and that saves switching power. Inputs that are not members always pass through.

The rail has two possible sources. One is a plain rail pin. The other is an internal free-running tick generator that is high for a fixed part of each period, which is the kind of counter-driven source the block is meant to accept. A master enable turns the whole gating function on or off. When the function is on, the observation output mirrors the rail source so the rail can be inspected from outside. When it is off, no input is ever blocked, and the observation output carries an auxiliary user level like an ordinary output.

Every path is registered once on the block clock, so all outputs change only on clock edges, one cycle after the inputs that cause them.

Top module: `pin_freeze_gate`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), gated_out is all zeros and rail_obs is 0.
- R2: A bit i with part_mask[i]=0 is never blocked: gated_out[i] after a clock edge equals pad_in[i] sampled at that edge, whatever the rail or enable.
- R3: A bit i with part_mask[i]=1 passes the same way as in R2 at every edge where the effective rail is low.
- R4: A bit i with part_mask[i]=1 shows zero transitions on gated_out[i] across all edges where the effective rail is high, however pad_in[i] toggles.
- R5: The value held during blocking is the pad_in value sampled at the last edge before blocking began, where the bit was still passing.
- R6: At the first edge where the effective rail is low again, gated_out[i] takes the pad_in[i] value sampled at that edge.
- R7: Rail source selection: rail_sel=0 uses rail_in. rail_sel=1 uses an internal tick counter that starts at 0 when reset is released and advances by one on every edge, wrapping from TICK_PERIOD-1 to 0. The tick rail is high while the count is below TICK_HIGH. The defaults are 8 and 3.
- R8: With gate_en=0 the effective rail is low, so no input is blocked. rail_obs after an edge equals aux_in sampled at that edge.
- R9: With gate_en=1 the effective rail equals the selected source. rail_obs after an edge equals the selected source sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | N_PINS | Raw input pin levels |
| part_mask | input | N_PINS | Membership mask; 1 = pin takes part in gating |
| gate_en | input | 1 | Master enable of the gating function |
| rail_sel | input | 1 | Rail source: 0 = rail_in pin, 1 = internal tick generator |
| rail_in | input | 1 | Rail level when driven from a pin |
| aux_in | input | 1 | User level shown on rail_obs when gating is off |
| gated_out | output | N_PINS | Registered, gated input levels toward internal logic |
| rail_obs | output | 1 | Registered rail source, or aux_in when gating is off |

## Verification
The bench attacks the edge where blocking begins and checks that the frozen value is the last passed sample. A design that captured one cycle late would freeze the first toggled value instead. It toggles frozen pins every cycle and counts edges on the member outputs. A design that leaked through or glitched on release would show a nonzero count or a stale value after the rail falls. It changes the mask while the rail is high, to catch logic that blocks non-members or decodes the mask only once. It runs the tick source over several periods to catch an off-by-one in the wrap or in the high count. It also turns the enable off with the rail held high, which exposes any design that still blocks inputs or keeps mirroring the rail.

// File: rtl/pin_freeze_pkg.sv
package pin_freeze_pkg;

  // Choose between the pin-driven rail and the internal tick rail.
  function automatic logic rail_pick(input logic use_tick, input logic pin_lvl,
                                     input logic tick_lvl);
    return use_tick ? tick_lvl : pin_lvl;
  endfunction

  // Tick rail is high for the first high_cnt counts of each period.
  function automatic logic tick_level(input logic [31:0] cnt, input logic [31:0] high_cnt);
    return cnt < high_cnt;
  endfunction

  // A lane is frozen only when gating is on, the rail is up and it is a member.
  function automatic logic lane_blocked(input logic en, input logic rail, input logic member);
    return en & rail & member;
  endfunction

  // Observation pin shows the rail while gating is on, otherwise the user level.
  function automatic logic obs_pick(input logic en, input logic rail, input logic aux);
    return en ? rail : aux;
  endfunction

endpackage

// File: rtl/rail_tick_gen.sv
module rail_tick_gen #(
  parameter int TICK_PERIOD = 8,
  parameter int TICK_HIGH   = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_lvl
);
  import pin_freeze_pkg::*;

  localparam int CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap_now;

  assign wrap_now = (cnt_q == LAST);
  assign tick_lvl = tick_level(32'(cnt_q), 32'(TICK_HIGH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wrap_now) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && wrap_now |=> cnt_q == '0); // R7
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !wrap_now |=> cnt_q == $past(cnt_q) + 1'b1); // R7
  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R7

endmodule

// File: rtl/hold_lane.sv
module hold_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic pad,
  input  logic blk,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (!blk) q <= pad;
  end

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && blk |=> $stable(q)); // R4
  AST_PASS_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !blk |=> q == $past(pad)); // R3

endmodule

// File: rtl/rail_mirror.sv
module rail_mirror (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_en,
  input  logic rail_src,
  input  logic aux_in,
  output logic obs
);
  import pin_freeze_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) obs <= 1'b0;
    else        obs <= obs_pick(gate_en, rail_src, aux_in);
  end

  AST_OBS_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && gate_en |=> obs == $past(rail_src)); // R9
  AST_OBS_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !gate_en |=> obs == $past(aux_in)); // R8

endmodule

// File: rtl/pin_freeze_gate.sv
module pin_freeze_gate #(
  parameter int N_PINS      = 16,
  parameter int TICK_PERIOD = 8,
  parameter int TICK_HIGH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pad_in,
  input  logic [N_PINS-1:0] part_mask,
  input  logic              gate_en,
  input  logic              rail_sel,
  input  logic              rail_in,
  input  logic              aux_in,
  output logic [N_PINS-1:0] gated_out,
  output logic              rail_obs
);
  import pin_freeze_pkg::*;

  logic              tick_lvl;
  logic              rail_src;
  logic              rail_eff;
  logic [N_PINS-1:0] blk_vec;

  rail_tick_gen #(
    .TICK_PERIOD(TICK_PERIOD),
    .TICK_HIGH  (TICK_HIGH)
  ) tick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_lvl(tick_lvl)
  );

  assign rail_src = rail_pick(rail_sel, rail_in, tick_lvl);
  assign rail_eff = gate_en & rail_src;

  for (genvar i = 0; i < N_PINS; i++) begin : g_lane
    assign blk_vec[i] = lane_blocked(gate_en, rail_src, part_mask[i]);
    hold_lane lane_i (
      .clk  (clk),
      .rst_n(rst_n),
      .pad  (pad_in[i]),
      .blk  (blk_vec[i]),
      .q    (gated_out[i])
    );
  end

  rail_mirror mirror_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_en (gate_en),
    .rail_src(rail_src),
    .aux_in  (aux_in),
    .obs     (rail_obs)
  );

  AST_NONMEMBER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((gated_out ^ $past(pad_in)) & ~$past(part_mask)) == '0); // R2
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !gate_en |=> gated_out == $past(pad_in)); // R8
  AST_RAIL_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !rail_eff |=> gated_out == $past(pad_in)); // R6
  AST_BLOCK_MEMBERS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_vec & ~part_mask) == '0); // R2

endmodule

// File: tb/pin_freeze_gate_tb.sv
`timescale 1ns/1ps
module pin_freeze_gate_tb_top;
  localparam int N = 16;
  localparam int P = 8;
  localparam int H = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] part_mask = '0;
  logic         gate_en = 1'b1;
  logic         rail_sel = 1'b0;
  logic         rail_in = 1'b0;
  logic         aux_in = 1'b0;
  logic [N-1:0] gated_out;
  logic         rail_obs;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pin_freeze_gate #(.N_PINS(N), .TICK_PERIOD(P), .TICK_HIGH(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .part_mask(part_mask),
    .gate_en(gate_en), .rail_sel(rail_sel), .rail_in(rail_in), .aux_in(aux_in),
    .gated_out(gated_out), .rail_obs(rail_obs));

  // Behavioural reference model, updated at every rising edge.
  logic [N-1:0] m_out;
  logic         m_obs;
  int           m_tick;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_obs = 1'b0; m_tick = 0;
    end else begin
      logic src;
      src = rail_sel ? (m_tick < H) : rail_in;
      for (int i = 0; i < N; i++)
        if (!(gate_en && src && part_mask[i])) m_out[i] = pad_in[i];
      m_obs = gate_en ? src : aux_in;
      m_tick = (m_tick + 1) % P;
    end
  end

  // Edge counter on watched outputs.
  logic [N-1:0] prev_out = '0;
  logic [N-1:0] watch_mask = '0;
  int           trans_cnt = 0;
  always @(gated_out) begin
    trans_cnt += $countones((gated_out ^ prev_out) & watch_mask);
    prev_out = gated_out;
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, gated_out, m_out);
    chk(req, {{(N-1){1'b0}}, rail_obs}, {{(N-1){1'b0}}, m_obs});
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] held;
    // R1: reset state
    pad_in = 16'hFFFF; aux_in = 1'b1; rail_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", gated_out, '0);
    chk("R1", {{(N-1){1'b0}}, rail_obs}, '0);
    rail_in = 1'b0; aux_in = 1'b0;
    rst_n = 1'b1;

    // R2 and R3: rail low, mixed membership
    part_mask = 16'h00FF;
    for (int k = 0; k < 10; k++) begin
      pad_in = N'($urandom); tick("R3");
    end

    // R4 and R5: rail high, members frozen, non-members follow
    pad_in = 16'hA55A; tick("R3");
    held = pad_in;
    rail_in = 1'b1; watch_mask = 16'h00FF; trans_cnt = 0;
    for (int k = 0; k < 10; k++) begin
      pad_in = ~pad_in ^ N'(k); tick("R2");
      chk("R5", gated_out & 16'h00FF, held & 16'h00FF);
    end
    chk("R4", N'(trans_cnt), '0);
    watch_mask = '0;

    // Mask change while rail high
    part_mask = 16'hF0F0;
    for (int k = 0; k < 6; k++) begin
      pad_in = N'($urandom); tick("R4");
    end

    // R6: release
    rail_in = 1'b0; pad_in = 16'h3C3C; tick("R6");
    chk("R6", gated_out, 16'h3C3C);

    // R7: internal tick rail over several periods
    rail_sel = 1'b1; part_mask = 16'hFFFF;
    for (int k = 0; k < 3 * P; k++) begin
      pad_in = N'($urandom); tick("R7");
    end

    // R8: gating off, rail held high on both sources
    gate_en = 1'b0; rail_in = 1'b1;
    for (int k = 0; k < 8; k++) begin
      pad_in = N'($urandom); aux_in = k[0]; tick("R8");
      chk("R8", gated_out, pad_in);
    end

    // R9: gating on, observation follows rail_in
    gate_en = 1'b1; rail_sel = 1'b0; part_mask = 16'h0F0F;
    for (int k = 0; k < 8; k++) begin
      rail_in = k[1]; aux_in = ~k[1]; pad_in = N'($urandom); tick("R9");
      chk("R9", {{(N-1){1'b0}}, rail_obs}, {{(N-1){1'b0}}, k[1]});
    end

    finish_run();
  end
endmodule